// File: doc/BRIEF.md
# Hardware Cursor Overlay Plane

This block draws a small cursor image on top of a display pixel stream that is already being scanned out. A cursor image of 64 by 64 pixels, each 32 bits wide with an 8-bit alpha byte above a 24-bit colour, sits in a local cursor memory. For every incoming pixel the block compares the raster coordinates with the programmed cursor position. When the pixel falls inside the cursor square, the block fetches the matching cursor word and lets a fully opaque cursor pixel replace the display pixel. Every other pixel passes through unchanged.

Software programs three registers: a mode register, a position register and an image base register. Mode and position writes land in staging copies only. A write to the base register arms the staged set. The armed set moves into the live registers at the next vertical-blank pulse, so a frame never mixes old and new cursor settings. Positions may be negative. In that case the cursor hangs off the top or left edge and only its visible part is drawn. The cursor memory is loaded through a plain write port.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the live mode is 0 and the live position and base are 0. Every pixel passes through unchanged, and out_valid is 0 while reset is held.
- R2: out_valid, out_sync and out_pix follow in_valid, in_sync and the selected pixel with exactly one clock cycle of latency.
- R3: Writes to the mode register (reg_addr 0, bits 2:0) and the position register (reg_addr 2) have no effect on the output until the base register is written, even if a vertical-blank pulse occurs in between.
- R4: A base register write (reg_addr 1) arms all staged values. They become live at the first vblank pulse after the write and not before. The live mode changes only in a cycle where vblank is high.
- R5: The position register holds the Y coordinate in bits 31:16 and the X coordinate in bits 15:0.
- R6: A pixel is inside the cursor when dx = raster_x - X and dy = raster_y - Y are both in 0..63. Outside that window the input pixel passes through.
- R7: The cursor word read for an inside pixel is at memory word (base/4 + dy*64 + dx) modulo the memory depth, so the image is stored row by row with 64 words per row.
- R8: An inside pixel is replaced by bits 23:0 of the cursor word only when bits 31:24 of that word equal 0xFF. Any other alpha value, including 0x00 and 0x80, leaves the input pixel in place.
- R9: The cursor is drawn only while the live mode equals 7. Any other mode, including 0 (disabled), passes all pixels through.
- R10: While pipe_en is low every pixel passes through unchanged.
- R11: Each coordinate is sign-magnitude: bit 15 set means negative and bits 14:0 hold the magnitude. A negative position shows only the rows and columns that land on non-negative raster coordinates.
- R12: A cycle with in_valid low is never overlaid. It produces out_valid low one cycle later and passes the pixel value through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 base, 2 position |
| reg_wdata | input | 32 | Register write data |
| vblank | input | 1 | Vertical-blank pulse that commits armed settings |
| pipe_en | input | 1 | Display pipe enable |
| mem_we | input | 1 | Cursor memory write strobe |
| mem_addr | input | ADDR_W (12) | Cursor memory word address |
| mem_wdata | input | 32 | Cursor memory write word (alpha in 31:24) |
| in_valid | input | 1 | Incoming pixel valid |
| in_sync | input | SYNC_W (2) | Incoming sync flags |
| in_pix | input | PIX_W (24) | Incoming display pixel |
| raster_x | input | RAST_W (12) | Raster column of the incoming pixel |
| raster_y | input | RAST_W (12) | Raster row of the incoming pixel |
| out_valid | output | 1 | Delayed pixel valid |
| out_sync | output | SYNC_W (2) | Delayed sync flags |
| out_pix | output | PIX_W (24) | Output pixel after overlay |

## Verification
The bench targets the window edges at dx and dy of 63 and 64, and one column to the left of the cursor. A design with an off-by-one compare would either drop the last cursor row or column, or paint a stray one. It checks a staged mode and position across a vblank with no base write, and a base write before and after vblank. A design that commits too early would show a cursor the frame never asked for, and one that ignores the arm would never show it. Negative positions written in sign-magnitude form catch a design that reads the field as two's complement, which would place the cursor tens of thousands of pixels away. A non-zero base whose image wraps past the end of memory, together with alpha values of 0x00 and 0x80, catches wrong row strides, a base that is not divided by four, and blending that treats partial alpha as opaque.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

   // Register select codes on reg_addr
   localparam logic [1:0] SEL_MODE = 2'd0;
   localparam logic [1:0] SEL_BASE = 2'd1;
   localparam logic [1:0] SEL_POS  = 2'd2;

   // Mode value that turns on the 64x64 ARGB cursor
   localparam logic [2:0] MODE_ARGB = 3'd7;

   // Opaque alpha code
   localparam logic [7:0] ALPHA_OPAQUE = 8'hFF;

   typedef struct packed {
      logic [2:0]  mode;
      logic [31:0] base;
      logic [15:0] pos_y;
      logic [15:0] pos_x;
   } cur_state_t;

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
   import cursor_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [1:0]  sel,
   input  logic [31:0] wdata,
   input  logic        vblank,
   output cur_state_t  live
);

   cur_state_t staged;
   logic       armed;

   // Staging copies take every write; the base write arms them.
   // An armed set moves to the live copy on a vblank pulse.
   // A base write in the same cycle as that pulse re-arms,
   // because the later assignment below wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged <= '0;
         live   <= '0;
         armed  <= 1'b0;
      end else begin
         if (vblank && armed) begin
            live  <= staged;
            armed <= 1'b0;
         end
         if (we) begin
            case (sel)
               SEL_MODE: staged.mode <= wdata[2:0];
               SEL_POS: begin
                  staged.pos_y <= wdata[31:16];
                  staged.pos_x <= wdata[15:0];
               end
               SEL_BASE: begin
                  staged.base <= wdata;
                  armed       <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/cursor_locate.sv
module cursor_locate #(
   parameter int RAST_W  = 12,
   parameter int CUR_DIM = 64,
   parameter int ADDR_W  = 12
) (
   input  logic [RAST_W-1:0] raster_x,
   input  logic [RAST_W-1:0] raster_y,
   input  logic [15:0]       pos_x,
   input  logic [15:0]       pos_y,
   input  logic [31:0]       base,
   output logic              hit,
   output logic [ADDR_W-1:0] rd_addr
);

   localparam int LOG2 = $clog2(CUR_DIM);
   localparam int SW   = 17;

   if (RAST_W > 15) begin : g_bad_rast
      $error("cursor_locate: RAST_W must not exceed 15");
   end
   if (ADDR_W > 30) begin : g_bad_addr
      $error("cursor_locate: ADDR_W must not exceed 30");
   end

   logic [15:0]        field [2];
   logic [RAST_W-1:0]  rpos  [2];
   logic signed [SW-1:0] coord [2];
   logic signed [SW-1:0] rast  [2];
   logic signed [SW-1:0] diff  [2];
   logic [1:0]         inwin;
   logic [LOG2-1:0]    off   [2];

   assign field[0] = pos_x;
   assign field[1] = pos_y;
   assign rpos[0]  = raster_x;
   assign rpos[1]  = raster_y;

   // One identical decoder per axis: sign-magnitude to signed,
   // raster minus cursor origin, window test and offset.
   for (genvar a = 0; a < 2; a++) begin : g_axis
      assign coord[a] = field[a][15] ? -$signed({2'b00, field[a][14:0]})
                                     :  $signed({2'b00, field[a][14:0]});
      assign rast[a]  = $signed({{(SW-RAST_W){1'b0}}, rpos[a]});
      assign diff[a]  = rast[a] - coord[a];
      assign inwin[a] = !diff[a][SW-1] && (diff[a] < $signed(SW'(CUR_DIM)));
      assign off[a]   = diff[a][LOG2-1:0];
   end

   assign hit     = &inwin;
   assign rd_addr = base[ADDR_W+1:2] + ADDR_W'({off[1], off[0]});

   logic unused_base;
   assign unused_base = ^{base[1:0], base[31:ADDR_W+2]};

endmodule

// File: rtl/cursor_store.sv
module cursor_store #(
   parameter int WORDS  = 4096,
   parameter int DATA_W = 32,
   parameter int ADDR_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
   import cursor_pkg::*;
#(
   parameter int PIX_W     = 24,
   parameter int SYNC_W    = 2,
   parameter int RAST_W    = 12,
   parameter int CUR_DIM   = 64,
   parameter int MEM_WORDS = 4096,
   localparam int ADDR_W   = $clog2(MEM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              vblank,
   input  logic              pipe_en,
   input  logic              mem_we,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [31:0]       mem_wdata,
   input  logic              in_valid,
   input  logic [SYNC_W-1:0] in_sync,
   input  logic [PIX_W-1:0]  in_pix,
   input  logic [RAST_W-1:0] raster_x,
   input  logic [RAST_W-1:0] raster_y,
   output logic              out_valid,
   output logic [SYNC_W-1:0] out_sync,
   output logic [PIX_W-1:0]  out_pix
);

   if (PIX_W > 24 || PIX_W < 1) begin : g_bad_pix
      $error("cursor_overlay: PIX_W must be 1..24");
   end
   if ((CUR_DIM & (CUR_DIM - 1)) != 0) begin : g_bad_dim
      $error("cursor_overlay: CUR_DIM must be a power of two");
   end
   if (CUR_DIM * CUR_DIM > MEM_WORDS) begin : g_bad_mem
      $error("cursor_overlay: memory smaller than one cursor image");
   end

   cur_state_t        act;
   logic              hit;
   logic [ADDR_W-1:0] rd_addr;
   logic [31:0]       rd_word;

   cursor_regs i_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we),
      .sel    (reg_addr),
      .wdata  (reg_wdata),
      .vblank (vblank),
      .live   (act)
   );

   cursor_locate #(
      .RAST_W  (RAST_W),
      .CUR_DIM (CUR_DIM),
      .ADDR_W  (ADDR_W)
   ) i_locate (
      .raster_x (raster_x),
      .raster_y (raster_y),
      .pos_x    (act.pos_x),
      .pos_y    (act.pos_y),
      .base     (act.base),
      .hit      (hit),
      .rd_addr  (rd_addr)
   );

   cursor_store #(
      .WORDS  (MEM_WORDS),
      .DATA_W (32),
      .ADDR_W (ADDR_W)
   ) i_store (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_addr),
      .wdata (mem_wdata),
      .raddr (rd_addr),
      .rdata (rd_word)
   );

   // Single pipeline stage aligned with the memory read
   logic              show_q;
   logic              valid_q;
   logic [SYNC_W-1:0] sync_q;
   logic [PIX_W-1:0]  pix_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         show_q  <= 1'b0;
         valid_q <= 1'b0;
         sync_q  <= '0;
         pix_q   <= '0;
      end else begin
         show_q  <= in_valid && hit && pipe_en && (act.mode == MODE_ARGB);
         valid_q <= in_valid;
         sync_q  <= in_sync;
         pix_q   <= in_pix;
      end
   end

   assign out_valid = valid_q;
   assign out_sync  = sync_q;
   assign out_pix   = (show_q && rd_word[31:24] == ALPHA_OPAQUE)
                      ? rd_word[PIX_W-1:0] : pix_q;

   logic unused_rd;
   assign unused_rd = ^rd_word;

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
   parameter int PIX_W  = 24,
   parameter int SYNC_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [SYNC_W-1:0] in_sync,
   input logic [PIX_W-1:0]  in_pix,
   input logic              pipe_en,
   input logic              vblank,
   input logic              out_valid,
   input logic [SYNC_W-1:0] out_sync,
   input logic [PIX_W-1:0]  out_pix,
   input logic [2:0]        act_mode,
   input logic              hit
);

   // R2: valid and sync delayed by one cycle
   a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_sync == $past(in_sync));

   // R4: live mode only moves on a vblank pulse
   a_r4_mode_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !vblank |=> $stable(act_mode));

   // R6: outside the window the pixel passes through
   a_r6_miss_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> out_pix == $past(in_pix));

   // R9: any mode other than 7 passes through
   a_r9_mode_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode != 3'd7) |=> out_pix == $past(in_pix));

   // R10: pipe disabled passes through
   a_r10_pipe_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !pipe_en |=> out_pix == $past(in_pix));

   // R12: idle cycles are never overlaid
   a_r12_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && out_pix == $past(in_pix)));

endmodule

bind cursor_overlay cursor_overlay_chk #(
   .PIX_W  (PIX_W),
   .SYNC_W (SYNC_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_sync   (in_sync),
   .in_pix    (in_pix),
   .pipe_en   (pipe_en),
   .vblank    (vblank),
   .out_valid (out_valid),
   .out_sync  (out_sync),
   .out_pix   (out_pix),
   .act_mode  (act.mode),
   .hit       (hit)
);

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;

   localparam int PIX_W  = 24;
   localparam int SYNC_W = 2;
   localparam int RAST_W = 12;
   localparam int WORDS  = 4096;
   localparam int AW     = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_we = 1'b0;
   logic [1:0]        reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic              vblank = 1'b0;
   logic              pipe_en = 1'b1;
   logic              mem_we = 1'b0;
   logic [AW-1:0]     mem_addr = '0;
   logic [31:0]       mem_wdata = '0;
   logic              in_valid = 1'b0;
   logic [SYNC_W-1:0] in_sync = '0;
   logic [PIX_W-1:0]  in_pix = '0;
   logic [RAST_W-1:0] raster_x = '0;
   logic [RAST_W-1:0] raster_y = '0;
   logic              out_valid;
   logic [SYNC_W-1:0] out_sync;
   logic [PIX_W-1:0]  out_pix;

   always #4ns clk = ~clk;

   cursor_overlay i_cursor_overlay (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .vblank(vblank), .pipe_en(pipe_en),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .in_valid(in_valid), .in_sync(in_sync), .in_pix(in_pix),
      .raster_x(raster_x), .raster_y(raster_y),
      .out_valid(out_valid), .out_sync(out_sync), .out_pix(out_pix)
   );

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   // Vector table: cursor at X=100, Y=50, base 0. Word -1 means outside.
   localparam int NV = 10;
   localparam int VX[NV] = '{100, 163, 164,  99,  100, 100,  163, 104, 106, 110};
   localparam int VY[NV] = '{ 50,  50,  50,  50,  113, 114,  113,  50,  50,  60};
   localparam int VW[NV] = '{  0,  63,  -1,  -1, 4032,  -1, 4095,   4,   6, 650};

   function automatic logic [31:0] img(int w);
      logic [23:0] rgb;
      logic [7:0]  a;
      rgb = 24'(w * 32'h0001_0307) ^ 24'h5A5A5A;
      a = (w % 9 == 4) ? 8'h00 : (w % 11 == 6) ? 8'h80 : 8'hFF;
      return {a, rgb};
   endfunction

   function automatic logic [PIX_W-1:0] expect_px(int w, logic [PIX_W-1:0] pix);
      logic [31:0] d;
      if (w < 0) return pix;
      d = img(w);
      return (d[31:24] == 8'hFF) ? d[PIX_W-1:0] : pix;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_reg(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic pulse_vblank();
      @(negedge clk);
      vblank = 1'b1;
      @(negedge clk);
      vblank = 1'b0;
   endtask

   // Drive one pixel, sample one cycle later at the next falling edge.
   task automatic pixel(string req, int rx, int ry, logic v, int word);
      logic [PIX_W-1:0]  p;
      logic [SYNC_W-1:0] s;
      p = 24'(32'h00C0FFEE ^ (rx * 977 + ry * 31));
      s = SYNC_W'(rx + ry);
      @(negedge clk);
      in_valid = v; in_sync = s; in_pix = p;
      raster_x = RAST_W'(rx); raster_y = RAST_W'(ry);
      @(negedge clk);
      check(req, 32'(out_pix), 32'(expect_px(word, p)));
      check("R2 valid", 32'(out_valid), 32'(v));
      check("R2 sync", 32'(out_sync), 32'(s));
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset valid", 32'(out_valid), 32'd0);
      rst_n = 1'b1;

      for (int w = 0; w < WORDS; w++) begin
         @(negedge clk);
         mem_we = 1'b1; mem_addr = AW'(w); mem_wdata = img(w);
      end
      @(negedge clk);
      mem_we = 1'b0;

      // R1: live state is mode 0 at (0,0): word 0 is opaque but unused
      pixel("R1 reset passthrough", 0, 0, 1'b1, -1);

      // R3: staged mode/pos without base write stay invisible
      wr_reg(2'd0, 32'h0000_0007);
      wr_reg(2'd2, {16'd50, 16'd100});
      pulse_vblank();
      pixel("R3 staged ignored", 100, 50, 1'b1, -1);

      // R4: base write arms, commit only on vblank
      wr_reg(2'd1, 32'h0000_0000);
      pixel("R4 before vblank", 100, 50, 1'b1, -1);
      pulse_vblank();
      pixel("R4 after vblank", 100, 50, 1'b1, 0);

      // R5 R6 R8: window edges and alpha handling from the table
      for (int i = 0; i < NV; i++)
         pixel($sformatf("R6 R8 R5 vector %0d", i), VX[i], VY[i], 1'b1, VW[i]);

      // R7: non-zero base, including wrap past the end of memory
      wr_reg(2'd1, 32'h0000_0400);
      pulse_vblank();
      pixel("R7 base offset", 102, 50, 1'b1, 258);
      pixel("R7 base wrap", 100, 113, 1'b1, 192);

      // R11: negative sign-magnitude position X=-3, Y=-2
      wr_reg(2'd2, {16'h8002, 16'h8003});
      wr_reg(2'd1, 32'h0000_0000);
      pulse_vblank();
      pixel("R11 negative origin", 0, 0, 1'b1, 131);
      pixel("R11 negative far corner", 60, 61, 1'b1, 4095);
      pixel("R11 negative right edge", 61, 0, 1'b1, -1);
      pixel("R11 negative bottom edge", 0, 62, 1'b1, -1);

      // R12: idle cycle over a visible cursor pixel
      pixel("R12 idle passthrough", 0, 0, 1'b0, -1);

      // R10: pipe disabled
      pipe_en = 1'b0;
      pixel("R10 pipe off", 0, 0, 1'b1, -1);
      pipe_en = 1'b1;
      pixel("R10 pipe back on", 0, 0, 1'b1, 131);

      // R9: mode 3 staged; old mode stays live until vblank
      wr_reg(2'd0, 32'h0000_0003);
      wr_reg(2'd1, 32'h0000_0000);
      pixel("R4 old mode kept", 0, 0, 1'b1, 131);
      pulse_vblank();
      pixel("R9 mode 3 passthrough", 0, 0, 1'b1, -1);

      // R9: disable sequence, mode 0 then base 0
      wr_reg(2'd0, 32'h0000_0007);
      wr_reg(2'd1, 32'h0000_0000);
      pulse_vblank();
      pixel("R9 re-enabled", 0, 0, 1'b1, 131);
      wr_reg(2'd0, 32'h0000_0000);
      wr_reg(2'd1, 32'h0000_0000);
      pulse_vblank();
      pixel("R9 disabled", 0, 0, 1'b1, -1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule